// File: doc/BRIEF.md
# Load-Reserved / Store-Conditional Reservation Tracker

This block sits beside a core's load/store path and handles the two halves of a lock-free update sequence. A load-reserved request fetches a 32-bit word from memory, hands it back as the rd result and remembers the address in a small reservation table. A later store-conditional request looks the address up in that table. If it is there, the write is sent to memory and the result is 0. If it is not, the write is dropped and the result is 1. The lookup always consumes the matching reservation, so only one store-conditional can win for each load-reserved.

The table holds a parameterised number of independent reservations, so several addresses can be armed at once. A load-reserved that carries a non-zero second-source register index is rejected as an illegal instruction without touching memory or the table. A synchronous clear input drops every reservation in one cycle, for example on a context switch.

Top module: `lrsc_tracker`

## Requirements
- R1: A load-reserved with req_kind=0 reads the word at req_addr through the memory port (mem_we=0). The value on mem_rdata appears on res_data with a one-cycle res_valid pulse, one cycle after mem_ack is sampled. The address is then reserved.
- R2: A load-reserved whose req_rs2 is non-zero pulses illegal_instr for one cycle, one cycle after acceptance. It makes no memory access, gives no res_valid and adds no reservation.
- R3: A store-conditional (req_kind=1) succeeds only when the table holds exactly req_addr. It then writes req_wdata to req_addr through the memory port (mem_we=1).
- R4: The result of a successful store-conditional is 0, given one cycle after mem_ack. A failed one returns 1, one cycle after acceptance, with no memory access.
- R5: A store-conditional removes the matching reservation when it checks it, so a second store-conditional to the same address fails.
- R6: Reservations on different addresses are independent. Consuming one leaves the others in place.
- R7: The table has ENTRIES slots. A new reservation fills the lowest free slot. When no slot is free it overwrites the slot at a round-robin victim pointer that starts at slot 0, so after filling the table in order the oldest entry goes first.
- R8: Reserving an address that is already reserved creates no second entry. One store-conditional then clears it.
- R9: Reset leaves the table empty. clear_all empties it on the next edge and takes precedence over a reservation made on the same edge.
- R10: req_ready is high exactly while the block is idle. mem_req stays high, with a stable address, until mem_ack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clear_all | input | 1 | Drop all reservations |
| req_valid | input | 1 | Request present |
| req_kind | input | 1 | 0 = load-reserved, 1 = store-conditional |
| req_addr | input | AW | Word address (rs1 value) |
| req_wdata | input | DW | Store data (rs2 value) |
| req_rs2 | input | RIW | Second-source register index |
| req_ready | output | 1 | Idle, request accepted |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, valid with mem_ack |
| mem_ack | input | 1 | Memory access complete |
| res_valid | output | 1 | One-cycle result pulse |
| res_data | output | DW | Value for rd |
| illegal_instr | output | 1 | One-cycle illegal-instruction pulse |

## Verification
The main sequence is tried with one pattern for each outcome. A store-conditional with no prior load tells a missing reservation apart from a stale one. A load followed by two stores shows that the reservation is consumed. Interleaved loads to two addresses show that the entries are independent. A store to a neighbouring word shows that only an exact address match counts. A load with a non-zero second source is followed by a store to the same address, which tells a rejected load apart from one that quietly reserved. A repeated load followed by two stores tells a duplicate entry apart from a single one. Filling the table beyond its size shows which entry is evicted. The read and write counts of the memory model show whether accesses were suppressed.

// File: rtl/lrsc_pkg.sv
package lrsc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2
  } lrsc_state_t;

  localparam logic KIND_LOAD_RES  = 1'b0;
  localparam logic KIND_STORE_CND = 1'b1;
endpackage

// File: rtl/lrsc_table.sv
module lrsc_table #(
  parameter int ENTRIES = 4,
  parameter int AW      = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic [AW-1:0] look_addr,
  input  logic          consume,
  output logic          hit,
  input  logic          ins_en,
  input  logic [AW-1:0] ins_addr
);
  localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] valid_q;
  logic [AW-1:0]      addr_q [ENTRIES];
  logic [ENTRIES-1:0] look_match, ins_match;
  logic [IW-1:0]      victim_q, free_idx, sel_idx;
  logic               any_free;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign look_match[g] = valid_q[g] && (addr_q[g] == look_addr);
    assign ins_match[g]  = valid_q[g] && (addr_q[g] == ins_addr);
  end

  assign hit = |look_match;

  // lowest free slot
  always_comb begin
    any_free = 1'b0;
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid_q[i]) begin
        any_free = 1'b1;
        free_idx = IW'(i);
      end
    end
    sel_idx = any_free ? free_idx : victim_q;
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      valid_q  <= '0;
      victim_q <= '0;
    end else begin
      if (consume) valid_q <= valid_q & ~look_match;
      if (ins_en && !(|ins_match)) begin
        valid_q[sel_idx] <= 1'b1;
        if (!any_free)
          victim_q <= (victim_q == IW'(ENTRIES - 1)) ? '0 : victim_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (ins_en && !(|ins_match)) addr_q[sel_idx] <= ins_addr;
  end
endmodule

// File: rtl/lrsc_ctrl.sv
module lrsc_ctrl
  import lrsc_pkg::*;
#(
  parameter int AW  = 32,
  parameter int DW  = 32,
  parameter int RIW = 5
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           req_valid,
  input  logic           req_kind,
  input  logic [AW-1:0]  req_addr,
  input  logic [DW-1:0]  req_wdata,
  input  logic [RIW-1:0] req_rs2,
  output logic           req_ready,
  output logic           mem_req,
  output logic           mem_we,
  output logic [AW-1:0]  mem_addr,
  output logic [DW-1:0]  mem_wdata,
  input  logic [DW-1:0]  mem_rdata,
  input  logic           mem_ack,
  output logic           res_valid,
  output logic [DW-1:0]  res_data,
  output logic           illegal_instr,
  input  logic           tbl_hit,
  output logic           tbl_consume,
  output logic           tbl_ins,
  output logic [AW-1:0]  tbl_ins_addr
);
  lrsc_state_t state_q;
  logic        accept;

  assign req_ready    = (state_q == ST_IDLE);
  assign accept       = req_valid && req_ready;
  assign tbl_consume  = accept && (req_kind == KIND_STORE_CND);
  assign tbl_ins      = (state_q == ST_READ) && mem_ack;
  assign tbl_ins_addr = mem_addr;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q       <= ST_IDLE;
      mem_req       <= 1'b0;
      mem_we        <= 1'b0;
      mem_addr      <= '0;
      mem_wdata     <= '0;
      res_valid     <= 1'b0;
      res_data      <= '0;
      illegal_instr <= 1'b0;
    end else begin
      res_valid     <= 1'b0;
      illegal_instr <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            if (req_kind == KIND_LOAD_RES) begin
              if (req_rs2 != '0) begin
                illegal_instr <= 1'b1;
              end else begin
                state_q  <= ST_READ;
                mem_req  <= 1'b1;
                mem_we   <= 1'b0;
                mem_addr <= req_addr;
              end
            end else if (tbl_hit) begin
              state_q   <= ST_WRITE;
              mem_req   <= 1'b1;
              mem_we    <= 1'b1;
              mem_addr  <= req_addr;
              mem_wdata <= req_wdata;
            end else begin
              res_valid <= 1'b1;
              res_data  <= DW'(1);
            end
          end
        end
        ST_READ: begin
          if (mem_ack) begin
            mem_req   <= 1'b0;
            res_valid <= 1'b1;
            res_data  <= mem_rdata;
            state_q   <= ST_IDLE;
          end
        end
        ST_WRITE: begin
          if (mem_ack) begin
            mem_req   <= 1'b0;
            mem_we    <= 1'b0;
            res_valid <= 1'b1;
            res_data  <= '0;
            state_q   <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lrsc_tracker.sv
module lrsc_tracker #(
  parameter int ENTRIES = 4,
  parameter int AW      = 32,
  parameter int DW      = 32,
  parameter int RIW     = 5
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           clear_all,
  input  logic           req_valid,
  input  logic           req_kind,
  input  logic [AW-1:0]  req_addr,
  input  logic [DW-1:0]  req_wdata,
  input  logic [RIW-1:0] req_rs2,
  output logic           req_ready,
  output logic           mem_req,
  output logic           mem_we,
  output logic [AW-1:0]  mem_addr,
  output logic [DW-1:0]  mem_wdata,
  input  logic [DW-1:0]  mem_rdata,
  input  logic           mem_ack,
  output logic           res_valid,
  output logic [DW-1:0]  res_data,
  output logic           illegal_instr
);
  logic          hit, consume, ins_en;
  logic [AW-1:0] ins_addr;

  lrsc_ctrl #(.AW(AW), .DW(DW), .RIW(RIW)) u_ctrl (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_kind(req_kind), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_rs2(req_rs2), .req_ready(req_ready),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .res_valid(res_valid), .res_data(res_data), .illegal_instr(illegal_instr),
    .tbl_hit(hit), .tbl_consume(consume), .tbl_ins(ins_en),
    .tbl_ins_addr(ins_addr)
  );

  lrsc_table #(.ENTRIES(ENTRIES), .AW(AW)) u_table (
    .clk(clk), .rst(rst), .clear(clear_all),
    .look_addr(req_addr), .consume(consume), .hit(hit),
    .ins_en(ins_en), .ins_addr(ins_addr)
  );
endmodule

// File: rtl/lrsc_tracker_chk.sv
module lrsc_tracker_chk #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          req_ready,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic          mem_ack,
  input logic          res_valid,
  input logic [DW-1:0] res_data,
  input logic          illegal_instr
);
  assert_read_done_R1: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_we && mem_ack) |=> res_valid);

  assert_pulse_R1: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> !res_valid);

  assert_illegal_nomem_R2: assert property (@(posedge clk) disable iff (rst)
    illegal_instr |-> (!mem_req && !res_valid));

  assert_write_zero_R4: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we && mem_ack) |=> (res_valid && res_data == '0));

  assert_req_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  assert_busy_R10: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> !req_ready);
endmodule

bind lrsc_tracker lrsc_tracker_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .req_ready(req_ready), .mem_req(mem_req),
  .mem_we(mem_we), .mem_addr(mem_addr), .mem_ack(mem_ack),
  .res_valid(res_valid), .res_data(res_data), .illegal_instr(illegal_instr)
);

// File: tb/lrsc_tracker_test.sv
module lrsc_tracker_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        clear_all = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_kind = 1'b0;
  logic [31:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [4:0]  req_rs2 = '0;
  logic        req_ready, mem_req, mem_we, res_valid, illegal_instr;
  logic [31:0] mem_addr, mem_wdata, res_data;
  logic [31:0] mem_rdata = '0;
  logic        mem_ack = 1'b0;

  int n_chk = 0, n_bad = 0, rd_cnt = 0, wr_cnt = 0;
  logic [31:0] mem [16];
  bit finished = 0;

  always #5 clk = ~clk;

  lrsc_tracker uut (.*);

  // memory model, one-cycle ack
  always @(posedge clk) begin
    if (mem_req && !mem_ack) begin
      mem_ack <= 1'b1;
      if (mem_we) begin
        mem[mem_addr[5:2]] <= mem_wdata;
        wr_cnt <= wr_cnt + 1;
      end else begin
        mem_rdata <= mem[mem_addr[5:2]];
        rd_cnt <= rd_cnt + 1;
      end
    end else begin
      mem_ack <= 1'b0;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  logic [31:0] g_data;
  logic        g_valid, g_ill;
  int          g_rd, g_wr;

  task automatic run_op(input logic kind, input logic [31:0] a, input logic [31:0] d, input logic [4:0] r2);
    int rd0, wr0;
    bit got;
    @(negedge clk);
    rd0 = rd_cnt; wr0 = wr_cnt;
    req_kind = kind; req_addr = a; req_wdata = d; req_rs2 = r2; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    got = 0; g_valid = 0; g_ill = 0; g_data = '0;
    for (int k = 0; k < 40 && !got; k++) begin
      if (res_valid || illegal_instr) begin
        got = 1; g_valid = res_valid; g_ill = illegal_instr; g_data = res_data;
      end else @(negedge clk);
    end
    @(negedge clk);
    g_rd = rd_cnt - rd0; g_wr = wr_cnt - wr0;
  endtask

  typedef struct packed {
    logic        kind;
    logic [31:0] addr;
    logic [31:0] wdata;
    logic [4:0]  rs2;
    logic [31:0] exp_data;
    logic        exp_ill;
    logic        exp_wr;
    logic        exp_rd;
  } vec_t;

  // kind 0 = load-reserved, 1 = store-conditional; memory word i preset to 0x1000+i
  localparam vec_t VECS [15] = '{
    '{1'b1, 32'h10, 32'hAA, 5'd0, 32'h1,    1'b0, 1'b0, 1'b0}, // R4 no reservation
    '{1'b0, 32'h10, 32'h0,  5'd0, 32'h1004, 1'b0, 1'b0, 1'b1}, // R1
    '{1'b1, 32'h10, 32'hAA, 5'd0, 32'h0,    1'b0, 1'b1, 1'b0}, // R3 R4 success
    '{1'b1, 32'h10, 32'hBB, 5'd0, 32'h1,    1'b0, 1'b0, 1'b0}, // R5 consumed
    '{1'b0, 32'h10, 32'h0,  5'd0, 32'hAA,   1'b0, 1'b0, 1'b1}, // R3 data landed
    '{1'b0, 32'h20, 32'h0,  5'd0, 32'h1008, 1'b0, 1'b0, 1'b1}, // R6 second address
    '{1'b1, 32'h14, 32'hCC, 5'd0, 32'h1,    1'b0, 1'b0, 1'b0}, // R3 exact match only
    '{1'b1, 32'h20, 32'hCC, 5'd0, 32'h0,    1'b0, 1'b1, 1'b0}, // R6
    '{1'b1, 32'h10, 32'hDD, 5'd0, 32'h0,    1'b0, 1'b1, 1'b0}, // R6 other kept
    '{1'b0, 32'h18, 32'h0,  5'd3, 32'h0,    1'b1, 1'b0, 1'b0}, // R2 illegal
    '{1'b1, 32'h18, 32'hEE, 5'd0, 32'h1,    1'b0, 1'b0, 1'b0}, // R2 nothing reserved
    '{1'b0, 32'h18, 32'h0,  5'd0, 32'h1006, 1'b0, 1'b0, 1'b1}, // R8
    '{1'b0, 32'h18, 32'h0,  5'd0, 32'h1006, 1'b0, 1'b0, 1'b1}, // R8 repeat
    '{1'b1, 32'h18, 32'hEE, 5'd0, 32'h0,    1'b0, 1'b1, 1'b0}, // R8
    '{1'b1, 32'h18, 32'hFF, 5'd0, 32'h1,    1'b0, 1'b0, 1'b0}  // R8 no duplicate
  };

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = 32'h1000 + i;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    chk(req_ready && !mem_req && !res_valid && !illegal_instr, "R10 reset state",
        {28'h0, req_ready, mem_req, res_valid, illegal_instr}, 32'h8);

    foreach (VECS[i]) begin
      run_op(VECS[i].kind, VECS[i].addr, VECS[i].wdata, VECS[i].rs2);
      chk(g_ill == VECS[i].exp_ill, $sformatf("vec%0d R2 illegal", i), 32'(g_ill), 32'(VECS[i].exp_ill));
      if (!VECS[i].exp_ill)
        chk(g_valid && g_data == VECS[i].exp_data, $sformatf("vec%0d R1/R4 result", i),
            g_data, VECS[i].exp_data);
      chk(g_wr == int'(VECS[i].exp_wr) && g_rd == int'(VECS[i].exp_rd),
          $sformatf("vec%0d R3 memory accesses rd/wr", i), 32'(g_rd * 16 + g_wr),
          32'(int'(VECS[i].exp_rd) * 16 + int'(VECS[i].exp_wr)));
    end

    // R9 clear_all drops reservations
    run_op(1'b0, 32'h04, 32'h0, 5'd0);
    @(negedge clk); clear_all = 1'b1;
    @(negedge clk); clear_all = 1'b0;
    run_op(1'b1, 32'h04, 32'h77, 5'd0);
    chk(g_valid && g_data == 32'h1 && g_wr == 0, "R9 clear_all", g_data, 32'h1);

    // R7 fill then evict oldest
    run_op(1'b0, 32'h00, 0, 0);
    run_op(1'b0, 32'h04, 0, 0);
    run_op(1'b0, 32'h08, 0, 0);
    run_op(1'b0, 32'h0C, 0, 0);
    run_op(1'b0, 32'h24, 0, 0);
    chk(g_data == 32'h1009, "R1 read idx9", g_data, 32'h1009);
    run_op(1'b1, 32'h00, 32'h55, 0);
    chk(g_data == 32'h1, "R7 oldest evicted", g_data, 32'h1);
    run_op(1'b1, 32'h04, 32'h55, 0);
    chk(g_data == 32'h0, "R7 next kept", g_data, 32'h0);
    run_op(1'b1, 32'h24, 32'h55, 0);
    chk(g_data == 32'h0, "R7 new entry", g_data, 32'h0);

    // R9 reset empties table
    run_op(1'b0, 32'h08, 0, 0);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    run_op(1'b1, 32'h08, 32'h66, 0);
    chk(g_data == 32'h1 && g_wr == 0, "R9 reset empties", g_data, 32'h1);

    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #200us;
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog R10 actual=%h expected=%h", 32'h0, 32'h1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule